// File: doc/BRIEF.md
# Partial-Word Byte Lane Packer

This block sits between a 32-bit register port and the byte-wide streams of a serial flash engine. On the transmit side, software writes a word to one of four data addresses, and the address selects how many bytes of that word are queued: all four, or only the lowest one, two or three. The queued bytes leave one per cycle through a ready/valid byte output, least significant lane first. Lanes above the selected count are never queued, so they can hold any filler.

On the receive side, incoming bytes are packed four to a word, with the earliest byte in lane 0, and pushed into a small word FIFO. Software reads that FIFO at a fixed address. The expected receive length is loaded when chip select rises. When a transfer ends on a short word, either because the length runs out or because chip select falls, the n valid bytes are placed in the upper n lanes. Software then shifts the word right by 8*(4-n) to recover them in arrival order.

A partial transmit word is only accepted while the byte queue is empty, and a full word only when four slots are free. A refused write is dropped and flagged for one cycle.

Top module: `spi_lane_packer`

## Requirements
- R1: After a synchronous active-low reset, `tx_byte_valid`, `rx_word_avail`, `tx_reject` and `rx_overflow` are 0.
- R2: A write to the full-word address (default 0x1C) queues all four bytes, and they are sent in the order lane 0 (bits 7:0), lane 1, lane 2, lane 3.
- R3: Writes to the one-, two- and three-byte addresses (defaults 0x80, 0x84, 0x88) queue only the lowest 1, 2 or 3 lanes, in lane order. The higher lanes are never sent.
- R4: A partial write that arrives while the byte queue holds data, or a full-word write that arrives with fewer than four free slots, is dropped. `tx_reject` is 1 for the cycle after the write, and the queued bytes are unchanged.
- R5: Four received bytes form one word with the earliest byte in lane 0. A read at the receive address (default 0x20) returns the oldest word and removes it.
- R6: The length loaded at the rising edge of `cs_active` counts the bytes accepted. When it runs out on the n-th byte of a word (n<4), that word is pushed with its bytes in lanes 4-n..3, the earliest byte in the lowest of them and zeros below.
- R7: A falling edge of `cs_active` with n (1..3) bytes packed pushes them with the same upper-lane alignment as R6.
- R8: Bytes that arrive while `cs_active` is 0, or after the loaded length is used up, are discarded.
- R9: A word completed while the word FIFO is full is dropped, `rx_overflow` is 1 for the next cycle, and the stored words are kept.
- R10: A read at the receive address with the FIFO empty, and a read at any other address, return 0 and remove nothing.
- R11: While `tx_byte_valid` is 1 and `tx_byte_ready` is 0, `tx_byte_valid` stays 1 and `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe; pops a word at the receive address |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd_en` |
| tx_reject | output | 1 | One-cycle pulse after a refused transmit write |
| tx_byte_valid | output | 1 | A queued transmit byte is available |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_byte_ready | input | 1 | Serial engine takes `tx_byte` |
| cs_active | input | 1 | Chip select asserted by the serial engine |
| xfer_len | input | LEN_W | Receive byte count, sampled when `cs_active` rises |
| rx_byte_valid | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte |
| rx_word_avail | output | 1 | The word FIFO holds at least one word |
| rx_overflow | output | 1 | One-cycle pulse after a dropped received word |

## Verification
Transmit packing is tried with one word at each of the four data addresses, using filler ones and zeros in the unused lanes. A lane ordering fault shows up in the per-byte comparison, and a wrong count shows up as an extra or missing byte. On the receive side, the lengths 8, 6, 7 and 5 end the transfer on 0, 2, 3 and 1 leftover bytes, so an alignment error in any of the three short shapes produces a distinct word. A chip select drop with three bytes pending separates the flush path from the length path. Surplus bytes, a full FIFO and reads at the wrong address show whether discarded input leaks into the stored words.

// File: rtl/lane_packer_pkg.sv
// Shared widths, types and the upper-lane alignment rule for the lane packer.
package lane_packer_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [2:0]        lane_cnt_t;   // 0..LANES

    // Move bytes held in lanes 0..n-1 up to lanes LANES-n..LANES-1.
    function automatic word_t upper_align(word_t w, lane_cnt_t n);
        return w << (LANE_W * (LANES - int'(n)));
    endfunction
endpackage

// File: rtl/lane_packer_decode.sv
// Address decode: turns a register write into a transmit lane count and
// flags reads of the receive word address. Purely combinational.
// Assumes the four transmit addresses and the receive address are distinct.
module lane_packer_decode
    import lane_packer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] TX4_ADDR = 'h1C,
    parameter logic [ADDR_W-1:0] TX1_ADDR = 'h80,
    parameter logic [ADDR_W-1:0] TX2_ADDR = 'h84,
    parameter logic [ADDR_W-1:0] TX3_ADDR = 'h88,
    parameter logic [ADDR_W-1:0] RXW_ADDR = 'h20
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              tx_hit,
    output lane_cnt_t         tx_lanes,
    output logic              rx_rd_hit
);
    // Select the byte count from the transmit address that was written.
    always_comb begin
        tx_hit   = 1'b0;
        tx_lanes = '0;
        if (wr_en) begin
            if (addr == TX4_ADDR) begin
                tx_hit = 1'b1; tx_lanes = lane_cnt_t'(LANES);
            end else if (addr == TX1_ADDR) begin
                tx_hit = 1'b1; tx_lanes = 3'd1;
            end else if (addr == TX2_ADDR) begin
                tx_hit = 1'b1; tx_lanes = 3'd2;
            end else if (addr == TX3_ADDR) begin
                tx_hit = 1'b1; tx_lanes = 3'd3;
            end
        end
    end

    assign rx_rd_hit = rd_en && (addr == RXW_ADDR);
endmodule

// File: rtl/lane_packer_txq.sv
// Transmit byte queue: accepts 1..4 lanes of a word in one cycle and emits
// one byte per cycle, lane 0 first. Partial words are taken only when empty;
// full words only with LANES free slots. DEPTH must be a power of two >= 4.
module lane_packer_txq
    import lane_packer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_en,
    input  lane_cnt_t push_lanes,
    input  word_t     push_word,
    output logic      out_valid,
    output lane_t     out_byte,
    input  logic      out_ready,
    output logic      reject
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    lane_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free_slots;
    logic             is_full_word, accept, pop;

    assign free_slots   = CNT_W'(DEPTH) - count;
    assign is_full_word = (push_lanes == lane_cnt_t'(LANES));
    assign accept       = push_en && (is_full_word ? (free_slots >= CNT_W'(LANES))
                                                   : (count == '0));
    assign out_valid    = (count != '0);
    assign out_byte     = mem[rd_ptr];
    assign pop          = out_valid && out_ready;

    // Store only the selected lanes of an accepted word.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(push_lanes))
                    mem[wr_ptr + PTR_W'(i)] <= push_word[i*LANE_W +: LANE_W];
            end
        end
    end

    // Advance pointers and occupancy; flag refused writes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            reject <= 1'b0;
        end else begin
            if (accept)
                wr_ptr <= wr_ptr + PTR_W'(push_lanes);
            if (pop)
                rd_ptr <= rd_ptr + 1'b1;
            count  <= count + (accept ? CNT_W'(push_lanes) : '0) - CNT_W'(pop);
            reject <= push_en && !accept;
        end
    end

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    a_r4_partial_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !is_full_word && count != '0) |=> reject);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/lane_packer_rxasm.sv
// Receive word assembler: packs bytes lane 0 upward, counts down the length
// loaded at chip-select rise, and emits short final words upper-aligned,
// either when the length runs out or when chip select falls.
module lane_packer_rxasm
    import lane_packer_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             byte_valid,
    input  lane_t            byte_in,
    output logic             word_push,
    output word_t            word_out
);
    logic             cs_q;
    lane_cnt_t        fill;
    word_t            acc, merged;
    logic [LEN_W-1:0] left, eff_left;
    logic             cs_rise, cs_fall, take, last;
    lane_cnt_t        new_fill;

    assign cs_rise  = cs_active && !cs_q;
    assign cs_fall  = !cs_active && cs_q;
    assign eff_left = cs_rise ? xfer_len : left;
    assign take     = byte_valid && cs_active && (eff_left != '0);
    assign last     = take && (eff_left == LEN_W'(1));
    assign new_fill = fill + lane_cnt_t'(take);

    // Drop the incoming byte into the next free lane.
    always_comb begin
        merged = acc;
        if (take)
            merged[int'(fill[1:0])*LANE_W +: LANE_W] = byte_in;
    end

    // Push a full word, a length-terminated short word or a chip-select flush.
    always_comb begin
        word_push = 1'b0;
        word_out  = '0;
        if (cs_fall && fill != '0) begin
            word_push = 1'b1;
            word_out  = upper_align(acc, fill);
        end else if (take && (new_fill == lane_cnt_t'(LANES) || last)) begin
            word_push = 1'b1;
            word_out  = upper_align(merged, new_fill);
        end
    end

    // Track chip select, packing state and remaining length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            fill <= '0;
            acc  <= '0;
            left <= '0;
        end else begin
            cs_q <= cs_active;
            if (cs_fall || word_push) begin
                fill <= '0;
                acc  <= '0;
            end else if (take) begin
                fill <= new_fill;
                acc  <= merged;
            end
            if (cs_fall)
                left <= '0;
            else if (cs_rise)
                left <= xfer_len - LEN_W'(take);
            else if (take)
                left <= left - 1'b1;
        end
    end

    a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (fill == '0));

    a_r6_fill_below_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_push |=> (fill == '0 || !cs_q));
endmodule

// File: rtl/lane_packer_wfifo.sv
// Receive word FIFO: stores packed words until software reads them. A push
// while full is dropped and flagged one cycle later. DEPTH is a power of two.
module lane_packer_wfifo
    import lane_packer_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  word_t push_word,
    input  logic  pop,
    output logic  avail,
    output word_t head,
    output logic  overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign avail   = (count != '0);
    assign head    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && avail;

    // Write an accepted word into storage.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_word;
    end

    // Move pointers, occupancy and the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count    <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            overflow <= push && full;
        end
    end

    a_r9_full_push_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow);

    a_r9_full_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/spi_lane_packer.sv
// Top level: register-side word interface to byte-wide serial streams.
// Transmit byte count comes from the write address; receive words are
// packed lane 0 upward with upper-aligned short final words.
module spi_lane_packer
    import lane_packer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = 16,
    parameter int TX_DEPTH = 16,
    parameter int RX_WORDS = 4,
    parameter logic [ADDR_W-1:0] TX4_ADDR = 'h1C,
    parameter logic [ADDR_W-1:0] TX1_ADDR = 'h80,
    parameter logic [ADDR_W-1:0] TX2_ADDR = 'h84,
    parameter logic [ADDR_W-1:0] TX3_ADDR = 'h88,
    parameter logic [ADDR_W-1:0] RXW_ADDR = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd_en,
    output logic [31:0]       reg_rdata,
    output logic              tx_reject,
    output logic              tx_byte_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_byte_ready,
    input  logic              cs_active,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_word_avail,
    output logic              rx_overflow
);
    logic      tx_hit, rx_rd_hit, asm_push;
    lane_cnt_t tx_lanes;
    word_t     asm_word, fifo_head;

    lane_packer_decode #(
        .ADDR_W(ADDR_W), .TX4_ADDR(TX4_ADDR), .TX1_ADDR(TX1_ADDR),
        .TX2_ADDR(TX2_ADDR), .TX3_ADDR(TX3_ADDR), .RXW_ADDR(RXW_ADDR)
    ) u_decode (
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .tx_hit(tx_hit), .tx_lanes(tx_lanes), .rx_rd_hit(rx_rd_hit)
    );

    lane_packer_txq #(.DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_en(tx_hit), .push_lanes(tx_lanes), .push_word(reg_wdata),
        .out_valid(tx_byte_valid), .out_byte(tx_byte), .out_ready(tx_byte_ready),
        .reject(tx_reject)
    );

    lane_packer_rxasm #(.LEN_W(LEN_W)) u_rxasm (
        .clk(clk), .rst_n(rst_n),
        .cs_active(cs_active), .xfer_len(xfer_len),
        .byte_valid(rx_byte_valid), .byte_in(rx_byte),
        .word_push(asm_push), .word_out(asm_word)
    );

    lane_packer_wfifo #(.DEPTH(RX_WORDS)) u_wfifo (
        .clk(clk), .rst_n(rst_n),
        .push(asm_push), .push_word(asm_word),
        .pop(rx_rd_hit), .avail(rx_word_avail), .head(fifo_head),
        .overflow(rx_overflow)
    );

    // Return the oldest word only for a read of the receive address.
    assign reg_rdata = (rx_rd_hit && rx_word_avail) ? fifo_head : '0;
endmodule

// File: tb/test_spi_lane_packer.sv
module test_spi_lane_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_reject, tx_byte_valid, tx_byte_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        cs_active = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_word_avail, rx_overflow;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_lane_packer i_spi_lane_packer (.*);

    // addr[42:35], data[34:3], lane count[2:0]
    localparam logic [42:0] TX_VEC [0:5] = '{
        {8'h1C, 32'h44332211, 3'd4},
        {8'h80, 32'hFFFFFFA5, 3'd1},
        {8'h84, 32'hFFFF5AC3, 3'd2},
        {8'h88, 32'hFF0F1E2D, 3'd3},
        {8'h1C, 32'hDEADBEEF, 3'd4},
        {8'h88, 32'h00ABCDEF, 3'd3}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd_en = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic take_tx(string req, logic [7:0] exp);
        chk(req, {31'd0, tx_byte_valid}, 32'd1);
        chk(req, {24'd0, tx_byte}, {24'd0, exp});
        tx_byte_ready = 1'b1;
        @(negedge clk);
        tx_byte_ready = 1'b0;
    endtask

    task automatic send_rx(logic [7:0] b);
        rx_byte = b; rx_byte_valid = 1'b1;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    task automatic cs_on(logic [15:0] len);
        cs_active = 1'b1; xfer_len = len;
        @(negedge clk);
    endtask

    task automatic cs_off();
        cs_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tx_byte_valid", {31'd0, tx_byte_valid}, 32'd0);
        chk("R1 rx_word_avail", {31'd0, rx_word_avail}, 32'd0);
        chk("R1 flags", {30'd0, tx_reject, rx_overflow}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: table of transmit words, one per address
        for (int v = 0; v < 6; v++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          n;
            string       req;
            a = TX_VEC[v][42:35]; d = TX_VEC[v][34:3]; n = int'(TX_VEC[v][2:0]);
            req = (n == 4) ? "R2" : "R3";
            reg_write(a, d);
            chk(req, {31'd0, tx_reject}, 32'd0);
            repeat (2) @(negedge clk);
            // R11: stalled byte held
            chk("R11", {24'd0, tx_byte}, {24'd0, d[7:0]});
            for (int k = 0; k < n; k++) take_tx(req, d[k*8 +: 8]);
            chk({req, " no extra lane"}, {31'd0, tx_byte_valid}, 32'd0);
        end

        // R4: partial write while queue busy
        reg_write(8'h1C, 32'h0D0C0B0A);
        reg_write(8'h84, 32'h00009999);
        chk("R4 partial busy", {31'd0, tx_reject}, 32'd1);
        for (int k = 0; k < 4; k++) take_tx("R4", 8'h0A + 8'(k));
        chk("R4 queue unchanged", {31'd0, tx_byte_valid}, 32'd0);

        // R4: full-word write with no room
        for (int w = 0; w < 4; w++) reg_write(8'h1C, {4{8'(w)}});
        chk("R4 room ok", {31'd0, tx_reject}, 32'd0);
        reg_write(8'h1C, 32'h77777777);
        chk("R4 no room", {31'd0, tx_reject}, 32'd1);
        begin
            int cnt = 0;
            while (tx_byte_valid && cnt < 24) begin
                tx_byte_ready = 1'b1; @(negedge clk); tx_byte_ready = 1'b0; cnt++;
            end
            chk("R4 drained count", 32'(cnt), 32'd16);
        end

        // R5: two full words
        cs_on(16'd8);
        for (int b = 1; b <= 8; b++) send_rx(8'(b));
        cs_off();
        reg_read(8'h20, rd); chk("R5 word0", rd, 32'h04030201);
        reg_read(8'h20, rd); chk("R5 word1", rd, 32'h08070605);
        chk("R5 empty", {31'd0, rx_word_avail}, 32'd0);

        // R6: length ends on 2, 3 and 1 leftover bytes
        cs_on(16'd6);
        for (int b = 0; b < 6; b++) send_rx(8'h11 + 8'(b));
        chk("R6 len6 avail before cs drop", {31'd0, rx_word_avail}, 32'd1);
        cs_off();
        reg_read(8'h20, rd); chk("R6 len6 w0", rd, 32'h14131211);
        reg_read(8'h20, rd); chk("R6 len6 tail", rd, 32'h16150000);
        chk("R6 len6 no flush", {31'd0, rx_word_avail}, 32'd0);
        cs_on(16'd7);
        for (int b = 0; b < 7; b++) send_rx(8'hA1 + 8'(b));
        cs_off();
        reg_read(8'h20, rd); chk("R6 len7 w0", rd, 32'hA4A3A2A1);
        reg_read(8'h20, rd); chk("R6 len7 tail", rd, 32'hA7A6A500);
        cs_on(16'd5);
        for (int b = 0; b < 5; b++) send_rx(8'h31 + 8'(b));
        cs_off();
        reg_read(8'h20, rd); chk("R6 len5 w0", rd, 32'h34333231);
        reg_read(8'h20, rd); chk("R6 len5 tail", rd, 32'h35000000);

        // R7: chip select drop with three bytes pending
        cs_on(16'd100);
        send_rx(8'hC1); send_rx(8'hC2); send_rx(8'hC3);
        chk("R7 nothing before drop", {31'd0, rx_word_avail}, 32'd0);
        cs_off();
        reg_read(8'h20, rd); chk("R7 flush", rd, 32'hC3C2C100);

        // R8: surplus bytes and bytes without chip select
        send_rx(8'hEE);
        @(negedge clk);
        chk("R8 no cs", {31'd0, rx_word_avail}, 32'd0);
        cs_on(16'd2);
        send_rx(8'hB1); send_rx(8'hB2); send_rx(8'hB3); send_rx(8'hB4);
        cs_off();
        reg_read(8'h20, rd); chk("R8 only length", rd, 32'hB2B10000);
        chk("R8 surplus dropped", {31'd0, rx_word_avail}, 32'd0);

        // R9: fifth word with FIFO full
        cs_on(16'd24);
        for (int b = 0; b < 16; b++) send_rx(8'h40 + 8'(b));
        chk("R9 no overflow yet", {31'd0, rx_overflow}, 32'd0);
        for (int b = 16; b < 20; b++) send_rx(8'h40 + 8'(b));
        chk("R9 overflow pulse", {31'd0, rx_overflow}, 32'd1);
        cs_off();
        reg_read(8'h20, rd); chk("R9 kept w0", rd, 32'h43424140);
        reg_read(8'h20, rd);
        reg_read(8'h20, rd);
        reg_read(8'h20, rd); chk("R9 kept w3", rd, 32'h4F4E4D4C);
        chk("R9 dropped", {31'd0, rx_word_avail}, 32'd0);

        // R10: empty read and read at another address
        reg_read(8'h20, rd); chk("R10 empty read", rd, 32'd0);
        cs_on(16'd4);
        for (int b = 0; b < 4; b++) send_rx(8'h91 + 8'(b));
        cs_off();
        reg_read(8'h1C, rd); chk("R10 other addr", rd, 32'd0);
        chk("R10 no pop", {31'd0, rx_word_avail}, 32'd1);
        reg_read(8'h20, rd); chk("R10 word kept", rd, 32'h94939291);

        summary();
        $finish;
    end
endmodule